// File: doc/BRIEF.md
# Four-Phase Bundled-Data Stage Controller

This block is the sequencing unit for a single stage of a bundled-data pipeline. It stands between an upstream request/acknowledge pair, a downstream request/acknowledge pair, and a local calculation unit that it controls with a go/finished pair. The handshake is level-based and return-to-zero. Every transfer has a rising half and then a falling half, and every wire is low again before the next transfer starts. When a request arrives, the controller launches the calculation. When the calculation reports that it has finished, the controller announces valid output data downstream. Only after the downstream side acknowledges does it acknowledge upstream. The falling half repeats the same order with every level reversed, and the calculation unit clears itself when go is lowered.

The controller is a clocked state machine. Its inputs are assumed to be already synchronised to `clk`. Every output comes straight from a flop.

An order guard watches for inputs that move out of turn, such as the finished line rising before go, or a downstream acknowledge with no downstream request. Such an event raises a sticky error flag. The machine holds its state for every cycle in which the event is present.

A phase counter steps once for each completed half. This gives a bench an independent view of progress.

States and transitions:
- `ST_IDLE`: all outputs low.
  - Upstream request high → `ST_COMPUTE`.
- `ST_COMPUTE`: go high.
  - Finished high → `ST_SEND`.
- `ST_SEND`: go and downstream request high.
  - Downstream acknowledge high → `ST_ACK_IN`. This completes the rising half.
- `ST_ACK_IN`: go, downstream request and upstream acknowledge high.
  - Upstream request low → `ST_RELEASE`.
- `ST_RELEASE`: go low.
  - Finished low → `ST_DRAIN`.
- `ST_DRAIN`: downstream request low.
  - Downstream acknowledge low → `ST_CLEAR_OUT`. This completes the falling half.
- `ST_CLEAR_OUT`: all outputs low.
  - Unconditionally → `ST_IDLE` on the next clock.
- In any state, an out-of-order input holds the current state.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `calc_go`, `dn_req`, `up_ack` and `proto_err` are 0 and `phase_cnt` is 0.
- R2: From idle, a high `up_req` raises `calc_go` one clock later, and no other output changes.
- R3: With `calc_go` high and `up_req` held high, `calc_fin` rising raises `dn_req` one clock later.
- R4: With `dn_req` high, `dn_ack` rising raises `up_ack` one clock later, and `phase_cnt` increments at that same edge.
- R5: Falling half, each step taking one clock:
  - `up_req` low lowers `calc_go`.
  - then `calc_fin` low lowers `dn_req`.
  - then `dn_ack` low lowers `up_ack`, and `phase_cnt` increments at that same edge.
- R6: While the awaited input has not arrived, all outputs hold their levels. No clock edge changes more than one of `calc_go`, `dn_req` and `up_ack`.
- R7: Each state requires two inputs to sit at fixed levels (upstream request / finished / downstream acknowledge; x means "this is the awaited input"):
  - idle: x/0/0
  - compute: 1/x/0
  - send: 1/1/x
  - ack_in: x/1/1
  - release: 0/x/1
  - drain: 0/0/x
  - clear_out: x/0/0

  A mismatch sets `proto_err` one clock later. The state (and so every output) is held for that clock, even if the awaited input is also present. `proto_err` stays high until reset.
- R8: `phase_cnt` is `CNT_W` bits wide and wraps to 0 after 2^`CNT_W` completed halves.
- R9: After `up_ack` falls, the controller spends one clock in clear-out. An `up_req` that rises right after `up_ack` falls raises `calc_go` two clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_req | input | 1 | Upstream request (input data valid) |
| up_ack | output | 1 | Upstream acknowledge |
| dn_req | output | 1 | Downstream request (output data valid) |
| dn_ack | input | 1 | Downstream acknowledge |
| calc_go | output | 1 | Starts the local calculation; low clears it |
| calc_fin | input | 1 | Local calculation finished |
| proto_err | output | 1 | Sticky out-of-order event flag |
| phase_cnt | output | CNT_W | Count of completed handshake halves |

## Verification
The bench drives complete transfers and checks that each output moves exactly one clock after its enabling input. A design that used an input combinationally, or added a pipeline stage, would move one cycle early or late.

It stalls the calculation and the downstream side for several cycles. A machine that advanced without the awaited event would drop or raise an output too soon.

It injects out-of-order events together with the awaited input: finished while idle, downstream acknowledge during compute, upstream request dropped during send. A guard that let the awaited input win would advance, and a non-sticky flag would clear itself.

Back-to-back transfers probe the clear-out latency. A narrow counter is run through its wrap point, where an off-by-one or saturating counter would show up.

// File: rtl/hs_ctrl_pkg.sv
package hs_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPUTE   = 3'd1,
        ST_SEND      = 3'd2,
        ST_ACK_IN    = 3'd3,
        ST_RELEASE   = 3'd4,
        ST_DRAIN     = 3'd5,
        ST_CLEAR_OUT = 3'd6
    } hs_state_e;

    // Levels of the three controller-driven wires.
    typedef struct packed {
        logic go;
        logic fwd;
        logic ack;
    } hs_drive_t;

    // Levels of the three wires the controller observes.
    typedef struct packed {
        logic req;
        logic fin;
        logic dack;
    } hs_sense_t;

    function automatic hs_drive_t drive_of(input hs_state_e s);
        hs_drive_t d;
        d = '0;
        unique case (s)
            ST_IDLE:      d = '{go: 1'b0, fwd: 1'b0, ack: 1'b0};
            ST_COMPUTE:   d = '{go: 1'b1, fwd: 1'b0, ack: 1'b0};
            ST_SEND:      d = '{go: 1'b1, fwd: 1'b1, ack: 1'b0};
            ST_ACK_IN:    d = '{go: 1'b1, fwd: 1'b1, ack: 1'b1};
            ST_RELEASE:   d = '{go: 1'b0, fwd: 1'b1, ack: 1'b1};
            ST_DRAIN:     d = '{go: 1'b0, fwd: 1'b0, ack: 1'b1};
            ST_CLEAR_OUT: d = '{go: 1'b0, fwd: 1'b0, ack: 1'b0};
            default:      d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hs_order_guard.sv
module hs_order_guard
    import hs_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hs_state_e state_q,
    input  hs_sense_t sense,
    output logic      awaited,
    output logic      violation,
    output logic      err_q
);

    // Per state: the awaited event, and the two inputs that must stay put.
    always_comb begin
        awaited   = 1'b0;
        violation = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                awaited   = sense.req;
                violation = sense.fin | sense.dack;
            end
            ST_COMPUTE: begin
                awaited   = sense.fin;
                violation = ~sense.req | sense.dack;
            end
            ST_SEND: begin
                awaited   = sense.dack;
                violation = ~sense.req | ~sense.fin;
            end
            ST_ACK_IN: begin
                awaited   = ~sense.req;
                violation = ~sense.fin | ~sense.dack;
            end
            ST_RELEASE: begin
                awaited   = ~sense.fin;
                violation = sense.req | ~sense.dack;
            end
            ST_DRAIN: begin
                awaited   = ~sense.dack;
                violation = sense.req | sense.fin;
            end
            ST_CLEAR_OUT: begin
                awaited   = 1'b1;
                violation = sense.fin | sense.dack;
            end
            default: begin
                awaited   = 1'b0;
                violation = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (violation) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      awaited,
    input  logic      violation,
    output hs_state_e state_q,
    output hs_state_e state_d,
    output logic      half_done
);

    always_comb begin
        state_d = state_q;
        if (!violation && awaited) begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_COMPUTE;
                ST_COMPUTE:   state_d = ST_SEND;
                ST_SEND:      state_d = ST_ACK_IN;
                ST_ACK_IN:    state_d = ST_RELEASE;
                ST_RELEASE:   state_d = ST_DRAIN;
                ST_DRAIN:     state_d = ST_CLEAR_OUT;
                ST_CLEAR_OUT: state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // A half completes when the upstream acknowledge is about to toggle.
    assign half_done = ((state_q == ST_SEND)  && (state_d == ST_ACK_IN)) ||
                       ((state_q == ST_DRAIN) && (state_d == ST_CLEAR_OUT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/hs_drive_reg.sv
module hs_drive_reg
    import hs_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hs_state_e state_d,
    output hs_drive_t drive_q
);

    // Outputs are decoded from the next state and registered: glitch-free,
    // and aligned with the state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
        end else begin
            drive_q <= drive_of(state_d);
        end
    end

endmodule

// File: rtl/hs_phase_counter.sv
module hs_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
    import hs_ctrl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req,
    output logic             up_ack,
    output logic             dn_req,
    input  logic             dn_ack,
    output logic             calc_go,
    input  logic             calc_fin,
    output logic             proto_err,
    output logic [CNT_W-1:0] phase_cnt
);

    hs_state_e state_q;
    hs_state_e state_d;
    hs_sense_t sense;
    hs_drive_t drive_q;
    logic      awaited;
    logic      violation;
    logic      half_done;

    assign sense = '{req: up_req, fin: calc_fin, dack: dn_ack};

    hs_order_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .sense     (sense),
        .awaited   (awaited),
        .violation (violation),
        .err_q     (proto_err)
    );

    hs_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .awaited   (awaited),
        .violation (violation),
        .state_q   (state_q),
        .state_d   (state_d),
        .half_done (half_done)
    );

    hs_drive_reg u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .drive_q (drive_q)
    );

    hs_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (half_done),
        .cnt_q (phase_cnt)
    );

    assign calc_go = drive_q.go;
    assign dn_req  = drive_q.fwd;
    assign up_ack  = drive_q.ack;

endmodule

// File: rtl/hs_stage_ctrl_chk.sv
module hs_stage_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_req,
    input logic             up_ack,
    input logic             dn_req,
    input logic             dn_ack,
    input logic             calc_go,
    input logic             calc_fin,
    input logic             proto_err,
    input logic [CNT_W-1:0] phase_cnt
);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!calc_go && !dn_req && !up_ack && !proto_err))
        else $error("R1 outputs not low in reset");

    a_r2_go_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calc_go) |-> $past(up_req))
        else $error("R2 go rose without request");

    a_r3_fwd_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> ($past(calc_fin) && calc_go))
        else $error("R3 downstream request out of order");

    a_r4_ack_after_dack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> ($past(dn_ack) && dn_req && calc_go))
        else $error("R4 upstream ack out of order");

    a_r5_fwd_drop_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_req) |-> (!calc_go && !$past(calc_fin)))
        else $error("R5 downstream request fell out of order");

    a_r5_ack_drop_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_ack) |-> (!dn_req && !$past(dn_ack)))
        else $error("R5 upstream ack fell out of order");

    a_r6_one_output_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({calc_go, dn_req, up_ack} ^ $past({calc_go, dn_req, up_ack})) <= 1)
        else $error("R6 more than one output moved");

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err)
        else $error("R7 error flag cleared");

    a_r7_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $stable({calc_go, dn_req, up_ack}))
        else $error("R7 state moved on violation");

    a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(up_ack) |-> (phase_cnt == CNT_W'($past(phase_cnt) + 1'b1)))
        else $error("R8 counter did not step");

    a_r8_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(up_ack) |-> $stable(phase_cnt))
        else $error("R8 counter moved without a half");

endmodule

bind hs_stage_ctrl hs_stage_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req    (up_req),
    .up_ack    (up_ack),
    .dn_req    (dn_req),
    .dn_ack    (dn_ack),
    .calc_go   (calc_go),
    .calc_fin  (calc_fin),
    .proto_err (proto_err),
    .phase_cnt (phase_cnt)
);

// File: tb/test_hs_stage_ctrl.sv
`timescale 1ns/1ps
module test_hs_stage_ctrl;

    localparam int TB_CNT_W = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                up_req = 1'b0;
    logic                dn_ack = 1'b0;
    logic                calc_fin = 1'b0;
    logic                up_ack;
    logic                dn_req;
    logic                calc_go;
    logic                proto_err;
    logic [TB_CNT_W-1:0] phase_cnt;

    logic [TB_CNT_W-1:0] exp_cnt;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hs_stage_ctrl #(.CNT_W(TB_CNT_W)) i_hs_stage_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .up_ack    (up_ack),
        .dn_req    (dn_req),
        .dn_ack    (dn_ack),
        .calc_go   (calc_go),
        .calc_fin  (calc_fin),
        .proto_err (proto_err),
        .phase_cnt (phase_cnt)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected {calc_go, dn_req, up_ack} as a 3-bit value.
    task automatic check_outs(input string tag, input logic [2:0] exp);
        check_val(tag, int'({calc_go, dn_req, up_ack}), int'(exp));
    endtask

    // Called at a negedge: drive inputs, let one posedge pass, return at next negedge.
    task automatic apply(input logic r, input logic f, input logic a);
        up_req   = r;
        calc_fin = f;
        dn_ack   = a;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        up_req   = 1'b0;
        calc_fin = 1'b0;
        dn_ack   = 1'b0;
        exp_cnt  = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full transfer from idle; ends in clear-out.
    task automatic run_transfer(input string tag);
        apply(1, 0, 0); check_outs({tag, " R2 go"}, 3'b100);
        apply(1, 1, 0); check_outs({tag, " R3 fwd"}, 3'b110);
        apply(1, 1, 1); check_outs({tag, " R4 ack"}, 3'b111);
        exp_cnt = exp_cnt + 1'b1;
        check_val({tag, " R4 cnt"}, int'(phase_cnt), int'(exp_cnt));
        apply(0, 1, 1); check_outs({tag, " R5 go low"}, 3'b011);
        apply(0, 0, 1); check_outs({tag, " R5 fwd low"}, 3'b001);
        apply(0, 0, 0); check_outs({tag, " R5 ack low"}, 3'b000);
        exp_cnt = exp_cnt + 1'b1;
        check_val({tag, " R5 cnt"}, int'(phase_cnt), int'(exp_cnt));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_req = 1'b1;
        @(negedge clk);
        check_outs("R1 outs in reset", 3'b000);
        check_val("R1 err in reset", int'(proto_err), 0);
        up_req = 1'b0;
        do_reset();
        check_outs("R1 outs after reset", 3'b000);
        check_val("R1 cnt after reset", int'(phase_cnt), 0);
    endtask

    task automatic t_single();
        do_reset();
        run_transfer("single");
        check_val("single R7 no err", int'(proto_err), 0);
        apply(0, 0, 0);
    endtask

    task automatic t_stall();
        do_reset();
        apply(1, 0, 0);
        for (int i = 0; i < 5; i++) begin
            apply(1, 0, 0);
            check_outs("R6 stall in compute", 3'b100);
        end
        apply(1, 1, 0);
        for (int i = 0; i < 4; i++) begin
            apply(1, 1, 0);
            check_outs("R6 stall in send", 3'b110);
        end
        check_val("R6 cnt held in send", int'(phase_cnt), int'(exp_cnt));
        apply(1, 1, 1);
        exp_cnt = exp_cnt + 1'b1;
        apply(0, 1, 1); check_outs("R6 release", 3'b011);
        for (int i = 0; i < 3; i++) begin
            apply(0, 1, 1);
            check_outs("R6 stall in release", 3'b011);
        end
        apply(0, 0, 1);
        apply(0, 0, 0);
        exp_cnt = exp_cnt + 1'b1;
        check_val("R6 cnt after stall", int'(phase_cnt), int'(exp_cnt));
        check_val("R6 no err", int'(proto_err), 0);
        apply(0, 0, 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        run_transfer("b2b first");
        apply(1, 0, 0); check_outs("R9 clear-out delays go", 3'b000);
        apply(1, 0, 0); check_outs("R9 go after clear-out", 3'b100);
        apply(1, 1, 0); check_outs("R9 second fwd", 3'b110);
        apply(1, 1, 1);
        exp_cnt = exp_cnt + 1'b1;
        apply(0, 1, 1);
        apply(0, 0, 1);
        apply(0, 0, 0);
        exp_cnt = exp_cnt + 1'b1;
        check_val("R9 cnt after two", int'(phase_cnt), int'(exp_cnt));
        check_val("R9 no err", int'(proto_err), 0);
        apply(0, 0, 0);
    endtask

    task automatic t_err_early_fin();
        do_reset();
        apply(1, 1, 0);
        check_outs("R7 fin in idle holds", 3'b000);
        check_val("R7 fin in idle flags", int'(proto_err), 1);
        apply(1, 0, 0);
        check_outs("R7 resumes after violation", 3'b100);
        check_val("R7 flag sticky", int'(proto_err), 1);
    endtask

    task automatic t_err_dack_early();
        do_reset();
        apply(1, 0, 0); check_outs("R7 compute entered", 3'b100);
        apply(1, 0, 1);
        check_outs("R7 dack in compute holds", 3'b100);
        check_val("R7 dack in compute flags", int'(proto_err), 1);
        apply(1, 1, 1);
        check_outs("R7 fin ignored while dack high", 3'b100);
        apply(1, 1, 0);
        check_outs("R7 fin taken once clean", 3'b110);
    endtask

    task automatic t_err_req_drop();
        do_reset();
        apply(1, 0, 0);
        apply(1, 1, 0); check_outs("R7 send entered", 3'b110);
        apply(0, 1, 1);
        check_outs("R7 req drop in send holds", 3'b110);
        check_val("R7 req drop flags", int'(proto_err), 1);
        check_val("R7 cnt unchanged", int'(phase_cnt), 0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            run_transfer("wrap");
            apply(0, 0, 0);
        end
        check_val("R8 wrap to zero", int'(phase_cnt), 0);
        apply(1, 0, 0);
        apply(1, 1, 0);
        apply(1, 1, 1);
        check_val("R8 step after wrap", int'(phase_cnt), 1);
    endtask

    initial begin
        exp_cnt = '0;
        t_reset();
        t_single();
        t_stall();
        t_back_to_back();
        t_err_early_fin();
        t_err_dack_early();
        t_err_req_drop();
        t_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule